// File: doc/BRIEF.md
# Mailbox Request Framing Engine

This engine sits between a host-facing byte mailbox and a management backend. When the host says that a request is ready, the engine reads the header of the inbound buffer over a byte read port and checks the length byte. If the request asks for the interface capabilities, the engine builds a ten-byte answer itself. Any other request goes to the backend on a command stream. The sequence byte is held back, and an 8-bit rolling tag travels beside the command in its place.

The backend sends its reply on a response stream that carries a tag. The engine drops a reply whose tag is stale. For a matching reply it writes the outbound frame over a byte write port, putting the saved sequence byte back into the frame. A reply too large for the outbound buffer is turned into a short error frame. Once a frame is loaded, the engine clears its busy flag, raises host attention and pulses an interrupt request. Only one request is in flight at a time.

Both streams use valid/ready. On the command stream `cmd_valid`, `cmd_data`, `cmd_last` and `cmd_tag` hold steady until `cmd_ready` is seen high at a clock edge. On the response stream a beat is taken at any edge where `rsp_valid` and `rsp_ready` are both high. `rsp_tag` must stay constant through a frame, and each frame carries at least two bytes. `rsp_ready` is low at all times except while a response is awaited, so the backend is held off. The host keeps `in_count` (at most `IN_DEPTH`) and the inbound buffer stable while the engine works.

Top module: `mbx_frame_engine`

## Requirements
- R1: After reset `bbusy`, `b2h_atn`, `irq_req`, `cmd_valid` and `out_len` are 0. A `req_go` pulse while idle makes `bbusy` read 1 in the next cycle.
- R2: A request with `in_count` below 4 ends the run with no outbound write, no command, no `in_count_clr` and no interrupt, and `bbusy` stays 1.
- R3: If byte 0 is not `in_count` minus 1, the engine drops the request and pulses `in_count_clr` for one cycle. It makes no write, command or interrupt, and `bbusy` stays 1.
- R4: A request with byte 1 = 0x18 and byte 3 = 0x36 is answered without any command. The outbound bytes 0..9 are 9, byte1|0x04, byte 2, byte 3, 0, 1, min(`IN_DEPTH`,255), min(`OUT_DEPTH`,255), 10, 0, and `out_len` is 10.
- R5: Any other valid request of n bytes sends inbound bytes 1, 3, 4, ..., n-1 in that order on the command stream. Byte 2 is skipped, `cmd_last` marks the final byte, and `cmd_tag` equals the current tag, which is 0 after reset. Under back-pressure, valid and data hold steady.
- R6: A response whose tag differs from the current tag is consumed and dropped: no write, no interrupt, and the engine keeps waiting. A matching response advances the tag by one.
- R7: A matching response of n bytes (n <= `OUT_DEPTH`-2) is written as: byte 0 = n+1, byte 1 = response byte 0, byte 2 = the saved sequence byte, bytes 3..n+1 = response bytes 1..n-1. `out_len` becomes n+2.
- R8: A matching response with n > `OUT_DEPTH`-2 is written as the five bytes 4, response byte 0, sequence byte, response byte 1, 0xCA, and `out_len` becomes 5.
- R9: Loading a frame (local or backend) clears `bbusy`, sets `b2h_atn` and pulses `irq_req` for exactly one cycle. `atn_clr` clears `b2h_atn`, but a completion in the same cycle wins.
- R10: `rsp_ready` stays low except while a response is awaited, and no command is offered during that wait.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_go | input | 1 | Host pulse: request ready in inbound buffer |
| in_count | input | $clog2(IN_DEPTH+1) | Number of request bytes written by the host |
| in_rd_addr | output | $clog2(IN_DEPTH) | Inbound buffer read address |
| in_rd_data | input | 8 | Inbound buffer read data (same-cycle) |
| in_count_clr | output | 1 | Pulse asking the host side to zero its byte count |
| out_wr_en | output | 1 | Outbound buffer write strobe |
| out_wr_addr | output | $clog2(OUT_DEPTH) | Outbound buffer write address |
| out_wr_data | output | 8 | Outbound buffer write data |
| out_len | output | $clog2(OUT_DEPTH+1) | Length of the last loaded outbound frame |
| bbusy | output | 1 | Engine busy with a request |
| b2h_atn | output | 1 | Response available to the host |
| atn_clr | input | 1 | Host clears the attention flag |
| irq_req | output | 1 | One-cycle interrupt request event |
| cmd_valid | output | 1 | Command stream valid |
| cmd_ready | input | 1 | Command stream ready |
| cmd_data | output | 8 | Command stream byte |
| cmd_last | output | 1 | Final byte of the command |
| cmd_tag | output | TAG_W | Tag travelling with the command |
| rsp_valid | input | 1 | Response stream valid |
| rsp_ready | output | 1 | Response stream ready |
| rsp_data | input | 8 | Response stream byte |
| rsp_last | input | 1 | Final byte of the response |
| rsp_tag | input | TAG_W | Tag of the response frame |

## Verification
The assertions check these on every cycle: busy rising after a start, busy still set when the count is cleared, a silent end for short requests, no command during a local reply or a wait, steady command data under back-pressure, a one-cycle interrupt with busy clear and attention set, and the tag moving only when a frame completes. The exact byte layout of local, normal and error frames, the order of forwarded bytes, the dropping of a stale response and the capacity boundary between a normal and an error frame can be shown only by the bench's scenarios. The bench compares the written buffer there against frames it computes itself.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CHECK,
    ST_DECIDE,
    ST_LOCAL,
    ST_FWD,
    ST_WAIT
  } eng_st_t;

  localparam logic [7:0] NETFN_APP_REQ = 8'h18;
  localparam logic [7:0] CMD_CAPS      = 8'h36;
  localparam logic [7:0] RSP_NETFN_BIT = 8'h04;
  localparam logic [7:0] CC_TOO_LARGE  = 8'hCA;
  localparam logic [7:0] CAP_MAX_OUTST = 8'd1;
  localparam logic [7:0] CAP_RSP_TIME  = 8'd10;
  localparam int         LOCAL_LEN     = 10;
endpackage

// File: rtl/mbx_cmd_fwd.sv
module mbx_cmd_fwd #(
  parameter int IC_W = 7,
  parameter int IA_W = 6
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [IC_W-1:0] len,
  output logic [IA_W-1:0] rd_addr,
  input  logic [7:0]      rd_data,
  output logic            cmd_valid,
  input  logic            cmd_ready,
  output logic [7:0]      cmd_data,
  output logic            cmd_last,
  output logic            done
);
  logic            active_q;
  logic [IC_W-1:0] ptr_q;

  assign rd_addr   = ptr_q[IA_W-1:0];
  assign cmd_valid = active_q;
  assign cmd_data  = rd_data;
  assign cmd_last  = (ptr_q == (len - IC_W'(1)));
  assign done      = active_q && cmd_ready && cmd_last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      ptr_q    <= '0;
    end else if (start) begin
      active_q <= 1'b1;
      ptr_q    <= IC_W'(1);
    end else if (active_q && cmd_ready) begin
      if (cmd_last) active_q <= 1'b0;
      else if (ptr_q == IC_W'(1)) ptr_q <= IC_W'(3);
      else ptr_q <= ptr_q + IC_W'(1);
    end
  end

  p_cmd_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !cmd_ready) |=> (cmd_valid && $stable(cmd_data) && $stable(cmd_last)));
endmodule

// File: rtl/mbx_rsp_load.sv
module mbx_rsp_load #(
  parameter int OUT_DEPTH = 64,
  parameter int TAG_W     = 8,
  parameter int CW        = 12,
  parameter int OA_W      = 6,
  parameter int OC_W      = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             arm,
  input  logic [TAG_W-1:0] tag,
  input  logic [7:0]       seq,
  input  logic             rsp_valid,
  output logic             rsp_ready,
  input  logic [7:0]       rsp_data,
  input  logic             rsp_last,
  input  logic [TAG_W-1:0] rsp_tag,
  output logic             wr_en,
  output logic [OA_W-1:0]  wr_addr,
  output logic [7:0]       wr_data,
  output logic             done,
  output logic [OC_W-1:0]  done_len
);
  import mbx_pkg::*;

  localparam logic [CW-1:0] LIMIT  = CW'(OUT_DEPTH - 2);
  localparam logic [CW-1:0] DEPTH  = CW'(OUT_DEPTH);
  localparam logic [CW-1:0] CNTMAX = '1;

  logic [CW-1:0] cnt_q, n_q, beat_addr;
  logic [1:0]    fin_q;
  logic          drop_q, first, keep, hs, err, beat_ok;

  assign first     = (cnt_q == '0);
  assign keep      = first ? (rsp_tag == tag) : !drop_q;
  assign rsp_ready = arm && (fin_q == 2'd0);
  assign hs        = rsp_valid && rsp_ready;
  assign err       = (n_q > LIMIT);
  assign beat_addr = first ? CW'(1) : (cnt_q + CW'(2));
  assign beat_ok   = keep && (cnt_q < DEPTH) && (beat_addr < DEPTH);
  assign done      = ((fin_q == 2'd2) && !err) || (fin_q == 2'd3);
  assign done_len  = err ? OC_W'(5) : OC_W'(n_q + CW'(2));

  always_comb begin
    wr_en   = 1'b0;
    wr_addr = '0;
    wr_data = rsp_data;
    unique case (fin_q)
      2'd1: begin
        wr_en   = 1'b1;
        wr_data = err ? 8'd4 : 8'(n_q + CW'(1));
      end
      2'd2: begin
        wr_en   = 1'b1;
        wr_addr = OA_W'(2);
        wr_data = seq;
      end
      2'd3: begin
        wr_en   = 1'b1;
        wr_addr = OA_W'(4);
        wr_data = CC_TOO_LARGE;
      end
      default: begin
        wr_en   = hs && beat_ok;
        wr_addr = beat_addr[OA_W-1:0];
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      n_q    <= '0;
      drop_q <= 1'b0;
      fin_q  <= 2'd0;
    end else begin
      if (hs) begin
        if (rsp_last) begin
          cnt_q  <= '0;
          drop_q <= 1'b0;
          if (keep) begin
            fin_q <= 2'd1;
            n_q   <= (cnt_q == CNTMAX) ? cnt_q : cnt_q + CW'(1);
          end
        end else begin
          if (cnt_q != CNTMAX) cnt_q <= cnt_q + CW'(1);
          if (first) drop_q <= (rsp_tag != tag);
        end
      end
      unique case (fin_q)
        2'd1:    fin_q <= 2'd2;
        2'd2:    fin_q <= err ? 2'd3 : 2'd0;
        2'd3:    fin_q <= 2'd0;
        default: ;
      endcase
    end
  end

  p_len_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (done_len <= OC_W'(OUT_DEPTH)));
endmodule

// File: rtl/mbx_frame_engine.sv
module mbx_frame_engine #(
  parameter int IN_DEPTH  = 64,
  parameter int OUT_DEPTH = 64,
  parameter int TAG_W     = 8,
  parameter int RSP_CW    = 12,
  localparam int IA_W = $clog2(IN_DEPTH),
  localparam int IC_W = $clog2(IN_DEPTH + 1),
  localparam int OA_W = $clog2(OUT_DEPTH),
  localparam int OC_W = $clog2(OUT_DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_go,
  input  logic [IC_W-1:0]  in_count,
  output logic [IA_W-1:0]  in_rd_addr,
  input  logic [7:0]       in_rd_data,
  output logic             in_count_clr,
  output logic             out_wr_en,
  output logic [OA_W-1:0]  out_wr_addr,
  output logic [7:0]       out_wr_data,
  output logic [OC_W-1:0]  out_len,
  output logic             bbusy,
  output logic             b2h_atn,
  input  logic             atn_clr,
  output logic             irq_req,
  output logic             cmd_valid,
  input  logic             cmd_ready,
  output logic [7:0]       cmd_data,
  output logic             cmd_last,
  output logic [TAG_W-1:0] cmd_tag,
  input  logic             rsp_valid,
  output logic             rsp_ready,
  input  logic [7:0]       rsp_data,
  input  logic             rsp_last,
  input  logic [TAG_W-1:0] rsp_tag
);
  import mbx_pkg::*;

  localparam logic [7:0] IN_CAP  = (IN_DEPTH  > 255) ? 8'hFF : 8'(IN_DEPTH);
  localparam logic [7:0] OUT_CAP = (OUT_DEPTH > 255) ? 8'hFF : 8'(OUT_DEPTH);

  eng_st_t          st_q;
  logic [1:0]       hidx_q;
  logic [7:0]       hdr_q [4];
  logic [3:0]       lidx_q;
  logic [TAG_W-1:0] tag_q;
  logic             busy_q, atn_q, irq_q, clr_q;
  logic [OC_W-1:0]  olen_q;

  logic             too_short, len_ok, is_caps, fwd_start, fwd_done;
  logic [IA_W-1:0]  fwd_addr;
  logic [7:0]       local_byte;
  logic             ld_wr_en, ld_done;
  logic [OA_W-1:0]  ld_wr_addr;
  logic [7:0]       ld_wr_data;
  logic [OC_W-1:0]  ld_len;
  logic             local_end;

  assign too_short = (in_count < IC_W'(4));
  assign len_ok    = (({24'd0, hdr_q[0]} + 32'd1) == 32'(in_count));
  assign is_caps   = (hdr_q[1] == NETFN_APP_REQ) && (hdr_q[3] == CMD_CAPS);
  assign fwd_start = (st_q == ST_DECIDE) && !too_short && len_ok && !is_caps;
  assign local_end = (st_q == ST_LOCAL) && (lidx_q == 4'(LOCAL_LEN - 1));

  assign in_rd_addr   = (st_q == ST_FWD) ? fwd_addr : IA_W'(hidx_q);
  assign in_count_clr = clr_q;
  assign out_len      = olen_q;
  assign bbusy        = busy_q;
  assign b2h_atn      = atn_q;
  assign irq_req      = irq_q;
  assign cmd_tag      = tag_q;

  always_comb begin
    unique case (lidx_q)
      4'd0:    local_byte = 8'(LOCAL_LEN - 1);
      4'd1:    local_byte = hdr_q[1] | RSP_NETFN_BIT;
      4'd2:    local_byte = hdr_q[2];
      4'd3:    local_byte = hdr_q[3];
      4'd5:    local_byte = CAP_MAX_OUTST;
      4'd6:    local_byte = IN_CAP;
      4'd7:    local_byte = OUT_CAP;
      4'd8:    local_byte = CAP_RSP_TIME;
      default: local_byte = 8'd0;
    endcase
  end

  assign out_wr_en   = (st_q == ST_LOCAL) || ld_wr_en;
  assign out_wr_addr = (st_q == ST_LOCAL) ? OA_W'(lidx_q) : ld_wr_addr;
  assign out_wr_data = (st_q == ST_LOCAL) ? local_byte : ld_wr_data;

  mbx_cmd_fwd #(.IC_W(IC_W), .IA_W(IA_W)) u_fwd (
    .clk(clk), .rst_n(rst_n), .start(fwd_start), .len(in_count),
    .rd_addr(fwd_addr), .rd_data(in_rd_data),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_data(cmd_data),
    .cmd_last(cmd_last), .done(fwd_done)
  );

  mbx_rsp_load #(.OUT_DEPTH(OUT_DEPTH), .TAG_W(TAG_W), .CW(RSP_CW),
                 .OA_W(OA_W), .OC_W(OC_W)) u_load (
    .clk(clk), .rst_n(rst_n), .arm(st_q == ST_WAIT), .tag(tag_q), .seq(hdr_q[2]),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data),
    .rsp_last(rsp_last), .rsp_tag(rsp_tag),
    .wr_en(ld_wr_en), .wr_addr(ld_wr_addr), .wr_data(ld_wr_data),
    .done(ld_done), .done_len(ld_len)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      hidx_q <= '0;
      lidx_q <= '0;
      tag_q  <= '0;
      busy_q <= 1'b0;
      atn_q  <= 1'b0;
      irq_q  <= 1'b0;
      clr_q  <= 1'b0;
      olen_q <= '0;
      for (int i = 0; i < 4; i++) hdr_q[i] <= '0;
    end else begin
      irq_q <= 1'b0;
      clr_q <= 1'b0;
      if (atn_clr) atn_q <= 1'b0;
      unique case (st_q)
        ST_IDLE: if (req_go) begin
          busy_q <= 1'b1;
          hidx_q <= '0;
          st_q   <= ST_CHECK;
        end
        ST_CHECK: begin
          hdr_q[hidx_q] <= in_rd_data;
          hidx_q        <= hidx_q + 2'd1;
          if (hidx_q == 2'd3) st_q <= ST_DECIDE;
        end
        ST_DECIDE: begin
          if (too_short) st_q <= ST_IDLE;
          else if (!len_ok) begin
            clr_q <= 1'b1;
            st_q  <= ST_IDLE;
          end else if (is_caps) begin
            lidx_q <= '0;
            st_q   <= ST_LOCAL;
          end else st_q <= ST_FWD;
        end
        ST_LOCAL: begin
          lidx_q <= lidx_q + 4'd1;
          if (local_end) st_q <= ST_IDLE;
        end
        ST_FWD:  if (fwd_done) st_q <= ST_WAIT;
        ST_WAIT: if (ld_done) begin
          tag_q <= tag_q + TAG_W'(1);
          st_q  <= ST_IDLE;
        end
        default: st_q <= ST_IDLE;
      endcase
      if (local_end || ld_done) begin
        busy_q <= 1'b0;
        atn_q  <= 1'b1;
        irq_q  <= 1'b1;
        olen_q <= local_end ? OC_W'(LOCAL_LEN) : ld_len;
      end
    end
  end

  p_busy_on_go_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_IDLE && req_go) |=> bbusy);
  p_short_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_DECIDE && too_short) |=> (st_q == ST_IDLE && !irq_req && !in_count_clr && bbusy));
  p_clr_keeps_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
    in_count_clr |-> (bbusy && !irq_req));
  p_local_no_cmd_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_LOCAL) |-> !cmd_valid);
  p_tag_moves_on_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(tag_q) |-> irq_req);
  p_irq_one_cycle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |=> !irq_req);
  p_irq_flags_r9: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> (!bbusy && b2h_atn));
  p_no_cmd_in_wait_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_WAIT) |-> !cmd_valid);
endmodule

// File: tb/mbx_frame_engine_tb.sv
module mbx_frame_engine_tb;
  localparam int IN_D  = 40;
  localparam int OUT_D = 16;
  localparam int IA_W  = $clog2(IN_D);
  localparam int IC_W  = $clog2(IN_D + 1);
  localparam int OA_W  = $clog2(OUT_D);
  localparam int OC_W  = $clog2(OUT_D + 1);

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic            rst_n = 1'b0, req_go = 1'b0, atn_clr = 1'b0;
  logic [IC_W-1:0] in_count = '0;
  logic [IA_W-1:0] in_rd_addr;
  logic [7:0]      in_rd_data;
  logic            in_count_clr, out_wr_en, bbusy, b2h_atn, irq_req;
  logic [OA_W-1:0] out_wr_addr;
  logic [7:0]      out_wr_data;
  logic [OC_W-1:0] out_len;
  logic            cmd_valid, cmd_ready = 1'b0, cmd_last;
  logic [7:0]      cmd_data, cmd_tag;
  logic            rsp_valid = 1'b0, rsp_ready, rsp_last = 1'b0;
  logic [7:0]      rsp_data = '0, rsp_tag = '0;

  logic [7:0] ib [IN_D];
  logic [7:0] ob [OUT_D];
  logic [7:0] reqq[$], rspq[$], cmdq[$], expq[$];
  int nwr = 0, nclr = 0, nirq = 0, nlast = 0;
  logic [7:0] tag_seen = '0;
  int nchk = 0, nfail = 0;
  bit wd = 1'b0;

  assign in_rd_data = ib[in_rd_addr];

  mbx_frame_engine #(.IN_DEPTH(IN_D), .OUT_DEPTH(OUT_D)) u_dut (.*);

  always @(negedge clk) cmd_ready <= ~cmd_ready;

  always @(posedge clk) begin
    if (out_wr_en) begin ob[out_wr_addr] <= out_wr_data; nwr++; end
    if (in_count_clr) nclr++;
    if (irq_req) nirq++;
    if (cmd_valid && cmd_ready) begin
      cmdq.push_back(cmd_data);
      tag_seen = cmd_tag;
      if (cmd_last) nlast++;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic go_req();
    @(negedge clk);
    foreach (reqq[i]) ib[i] = reqq[i];
    in_count = IC_W'(reqq.size());
    req_go = 1'b1;
    @(negedge clk);
    req_go = 1'b0;
    chk("R1 busy after go", int'(bbusy), 1);
  endtask

  task automatic wait_irq(input string req);
    int t = 0;
    while (!irq_req && t < 400) begin @(negedge clk); t++; end
    chk(req, int'(irq_req), 1);
  endtask

  task automatic wait_cmd(input int base);
    int t = 0;
    while (nlast == base && t < 400) begin @(negedge clk); t++; end
  endtask

  task automatic send_rsp(input logic [7:0] tg);
    for (int i = 0; i < rspq.size(); i++) begin
      @(negedge clk);
      rsp_valid = 1'b1; rsp_data = rspq[i]; rsp_tag = tg;
      rsp_last = (i == rspq.size() - 1);
      while (!rsp_ready) @(negedge clk);
    end
    @(negedge clk);
    rsp_valid = 1'b0; rsp_last = 1'b0;
  endtask

  task automatic chk_frame(input string req);
    foreach (expq[i]) chk(req, int'(ob[i]), int'(expq[i]));
    chk({req, " length"}, int'(out_len), expq.size());
  endtask

  task automatic chk_cmd(input string req, input int base, input int tg);
    chk({req, " count"}, cmdq.size() - base, expq.size());
    foreach (expq[i]) if (base + i < cmdq.size()) chk(req, int'(cmdq[base + i]), int'(expq[i]));
    chk({req, " tag"}, int'(tag_seen), tg);
  endtask

  task automatic run_all();
    int w0, c0, i0, b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 reset bbusy", int'(bbusy), 0);
    chk("R1 reset atn", int'(b2h_atn), 0);
    chk("R1 reset irq", int'(irq_req), 0);
    chk("R1 reset cmd_valid", int'(cmd_valid), 0);
    chk("R1 reset out_len", int'(out_len), 0);

    // R10: response offered while idle is held off
    w0 = nwr;
    rsp_valid = 1'b1; rsp_data = 8'h11; rsp_last = 1'b1;
    repeat (3) begin @(negedge clk); chk("R10 ready low idle", int'(rsp_ready), 0); end
    rsp_valid = 1'b0; rsp_last = 1'b0;
    chk("R10 no writes", nwr - w0, 0);

    // R2: short request
    w0 = nwr; c0 = nclr; i0 = nirq; b0 = cmdq.size();
    reqq = {8'h02, 8'h18, 8'h01};
    go_req();
    repeat (12) @(negedge clk);
    chk("R2 no writes", nwr - w0, 0);
    chk("R2 no clr", nclr - c0, 0);
    chk("R2 no irq", nirq - i0, 0);
    chk("R2 no cmd", cmdq.size() - b0, 0);
    chk("R2 busy stays", int'(bbusy), 1);

    // R3: length mismatch
    w0 = nwr; c0 = nclr; i0 = nirq;
    reqq = {8'h05, 8'h18, 8'h01, 8'h22};
    go_req();
    repeat (12) @(negedge clk);
    chk("R3 one clr", nclr - c0, 1);
    chk("R3 no writes", nwr - w0, 0);
    chk("R3 no irq", nirq - i0, 0);
    chk("R3 busy stays", int'(bbusy), 1);

    // R4: local capability answer
    b0 = cmdq.size(); i0 = nirq;
    reqq = {8'h03, 8'h18, 8'h55, 8'h36};
    go_req();
    wait_irq("R4 irq");
    expq = {8'd9, 8'h1C, 8'h55, 8'h36, 8'd0, 8'd1, 8'(IN_D), 8'(OUT_D), 8'd10, 8'd0};
    chk_frame("R4 frame");
    chk("R4 no cmd", cmdq.size() - b0, 0);
    chk("R9 busy clear", int'(bbusy), 0);
    chk("R9 atn set", int'(b2h_atn), 1);
    repeat (3) @(negedge clk);
    chk("R9 one irq pulse", nirq - i0, 1);
    atn_clr = 1'b1;
    @(negedge clk);
    atn_clr = 1'b0;
    chk("R9 atn cleared", int'(b2h_atn), 0);

    // R5/R6/R7: forwarded request, stale then matching response
    b0 = cmdq.size(); c0 = nlast;
    reqq = {8'h05, 8'h18, 8'h77, 8'h01, 8'hAA, 8'hBB};
    go_req();
    wait_cmd(c0);
    expq = {8'h18, 8'h01, 8'hAA, 8'hBB};
    chk_cmd("R5 cmd", b0, 0);
    w0 = nwr; i0 = nirq;
    rspq = {8'h1C, 8'h01, 8'h00};
    send_rsp(8'h05);
    repeat (4) @(negedge clk);
    chk("R6 stale no writes", nwr - w0, 0);
    chk("R6 stale no irq", nirq - i0, 0);
    chk("R6 still waiting", int'(rsp_ready), 1);
    rspq = {8'h1C, 8'h01, 8'h00, 8'h42};
    send_rsp(8'h00);
    wait_irq("R7 irq");
    expq = {8'd5, 8'h1C, 8'h77, 8'h01, 8'h00, 8'h42};
    chk_frame("R7 frame");

    // R6/R8: tag advanced, oversize response
    b0 = cmdq.size(); c0 = nlast;
    reqq = {8'h04, 8'h2C, 8'h10, 8'h09, 8'h33};
    go_req();
    wait_cmd(c0);
    expq = {8'h2C, 8'h09, 8'h33};
    chk_cmd("R6 tag step cmd", b0, 1);
    rspq = {8'h30, 8'h09};
    for (int k = 0; k < 13; k++) rspq.push_back(8'(8'h60 + k));
    send_rsp(8'h01);
    wait_irq("R8 irq");
    expq = {8'd4, 8'h30, 8'h10, 8'h09, 8'hCA};
    chk_frame("R8 frame");

    // R7 boundary: largest response that still fits
    b0 = cmdq.size(); c0 = nlast;
    reqq = {8'h03, 8'h18, 8'h21, 8'h02};
    go_req();
    wait_cmd(c0);
    expq = {8'h18, 8'h02};
    chk_cmd("R5 short cmd", b0, 2);
    rspq = {8'h1C, 8'h02};
    for (int k = 0; k < 12; k++) rspq.push_back(8'(8'h80 + k));
    send_rsp(8'h02);
    wait_irq("R7 boundary irq");
    expq = {8'd15, 8'h1C, 8'h21, 8'h02};
    for (int k = 0; k < 12; k++) expq.push_back(8'(8'h80 + k));
    chk_frame("R7 boundary frame");
  endtask

  initial begin
    foreach (ib[i]) ib[i] = 8'h00;
    foreach (ob[i]) ob[i] = 8'h00;
    fork
      run_all();
      begin repeat (100000) @(posedge clk); wd = 1'b1; end
    join_any
    if (wd) begin
      nchk++; nfail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    end
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule